// File: doc/BRIEF.md
# Four-Channel External Interrupt Controller

This block turns four external interrupt pins into level-type interrupt requests for a downstream interrupt controller. Each pin passes through a two-flop synchronizer. A per-channel detector then looks for a level or an edge, as chosen by a sensitivity register and a polarity register. A detected trigger latches a pending flag. The flag drives that channel's request line and stays set until software clears it by writing 1 to its bit.

A channel is live only while its pin-function field selects the external-interrupt function. The reset function code is GPIO, which leaves the channel disabled. The highest channel, index 3 by default, also forwards an aggregated GPIO interrupt input onto its request line. That input does not touch the channel's pending flag.

Software reaches three 32-bit registers over a simple single-cycle read/write bus. Bit n of each register belongs to channel n, and every bit above bit 3 reads as zero.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mode, polarity and flag registers read zero and every request line is low.
- R2: Word address 0x0 holds the flag register, 0x4 the mode register and 0x8 the polarity register. Only bits 3:0 are stored, upper bits read zero, and any other address reads zero.
- R3: With mode bit 0 (level), a polarity bit of 0 triggers on a low pin and 1 triggers on a high pin. The flag appears on the third rising clock edge counted from the edge that first samples the new pin value.
- R4: With mode bit 1 (edge), a polarity bit of 0 triggers on a falling edge and 1 on a rising edge. A pin that holds steady, or moves in the other direction, sets nothing.
- R5: Each request line follows its channel's pending flag, and the flag register reads back the same pending bits.
- R6: Writing 1 to a flag bit at 0x0 clears it. Writing 0 leaves it unchanged, and a flag with no clear stays set.
- R7: A level-mode channel whose pin is still active when its flag is cleared is pending again in the cycle that follows the clear write.
- R8: When a clear write and a new trigger hit the same channel in the same cycle, the flag stays set.
- R9: A channel whose 2-bit function field pin_func[2n+1:2n] is not 2'b01 never sets its flag. Once the field becomes 2'b01 with the pin already active in level mode, the flag sets on the next edge.
- R10: While gpio_irq is high, request line 3 is high, and bit 3 of the flag register is not affected by gpio_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| gpio_irq | input | 1 | Aggregated GPIO interrupt shared onto channel 3 |
| pin_func | input | 8 | Per-channel pin function field, 2 bits each; 2'b01 enables the channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_req | output | 4 | Interrupt request lines |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit data path, a 4-bit address and two synchronizer stages. This keeps the bench's cycle-level model of synchronizer, detector and flag exact. With four channels, one random cycle can mix level and edge channels, both polarities, a disabled channel and the shared GPIO line. Directed sequences line a clear write up with a fresh edge in the same cycle, clear a level channel while its pin is still active, and enable a channel whose pin is already active.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   // Register selected by the word part of the bus address
   typedef enum logic [1:0] {
      SEL_FLAG = 2'd0,
      SEL_MODE = 2'd1,
      SEL_POL  = 2'd2,
      SEL_NONE = 2'd3
   } ext_irq_sel_e;

   // Word index of each register
   localparam int unsigned WORD_FLAG = 0;
   localparam int unsigned WORD_MODE = 1;
   localparam int unsigned WORD_POL  = 2;

   // Function code that hands a pin to its interrupt channel
   localparam logic [1:0] FUNC_EXT_IRQ = 2'b01;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ext_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ext_irq_func_dec.sv
module ext_irq_func_dec
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter logic [1:0]  FUNC_CODE = FUNC_EXT_IRQ
) (
   input  logic [2*NUM_CH-1:0] pin_func,
   output logic [NUM_CH-1:0]   ch_en
);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign ch_en[n] = (pin_func[2*n +: 2] == FUNC_CODE);
   end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] smp,     // synchronized pin sample
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] mode,    // 0 level, 1 edge
   input  logic [NUM_CH-1:0] pol,     // 0 low/falling, 1 high/rising
   output logic [NUM_CH-1:0] prev,
   output logic [NUM_CH-1:0] trig
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic at_level;
      logic moved;
      assign at_level = ~(smp[n] ^ pol[n]);
      assign moved    = smp[n] ^ prev[n];
      always_comb begin
         if (!ch_en[n])    trig[n] = 1'b0;
         else if (mode[n]) trig[n] = at_level & moved;
         else              trig[n] = at_level;
      end
   end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] trig,
   output logic [NUM_CH-1:0] mode_q,
   output logic [NUM_CH-1:0] pol_q,
   output logic [NUM_CH-1:0] flag_q,
   output logic [NUM_CH-1:0] clr_vec
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   ext_irq_sel_e      sel;
   logic              wr_hit;
   logic              rd_hit;
   logic [NUM_CH-1:0] flag_d;
   logic              unused_bits;

   assign word = bus_addr[ADDR_W-1:2];

   always_comb begin
      if      (word == WORD_W'(WORD_FLAG)) sel = SEL_FLAG;
      else if (word == WORD_W'(WORD_MODE)) sel = SEL_MODE;
      else if (word == WORD_W'(WORD_POL))  sel = SEL_POL;
      else                                 sel = SEL_NONE;
   end

   assign wr_hit = bus_sel & bus_wr;
   assign rd_hit = bus_sel & ~bus_wr;

   assign clr_vec = (wr_hit && sel == SEL_FLAG) ? bus_wdata[NUM_CH-1:0] : '0;

   // a trigger in the same cycle overrides the clear
   assign flag_d = trig | (flag_q & ~clr_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pol_q  <= '0;
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (wr_hit && sel == SEL_MODE) mode_q <= bus_wdata[NUM_CH-1:0];
         if (wr_hit && sel == SEL_POL)  pol_q  <= bus_wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         unique case (sel)
            SEL_FLAG: bus_rdata[NUM_CH-1:0] = flag_q;
            SEL_MODE: bus_rdata[NUM_CH-1:0] = mode_q;
            SEL_POL:  bus_rdata[NUM_CH-1:0] = pol_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHARED_CH   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   ext_pin,
   input  logic                gpio_irq,
   input  logic [2*NUM_CH-1:0] pin_func,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_CH-1:0]   irq_req
);

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("ext_irq_ctrl: NUM_CH must lie in 1..DATA_W");
   end
   if (SHARED_CH >= NUM_CH) begin : g_bad_shared
      $error("ext_irq_ctrl: SHARED_CH must name an existing channel");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ext_irq_ctrl: ADDR_W must cover three word registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] sync_s;
   logic [NUM_CH-1:0] sync_p;
   logic [NUM_CH-1:0] ch_en;
   logic [NUM_CH-1:0] trig;
   logic [NUM_CH-1:0] mode_q;
   logic [NUM_CH-1:0] pol_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] clr_vec;

   ext_irq_sync #(
      .WIDTH  (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_pin),
      .q     (sync_s)
   );

   ext_irq_func_dec #(
      .NUM_CH    (NUM_CH),
      .FUNC_CODE (FUNC_EXT_IRQ)
   ) func_i (
      .pin_func (pin_func),
      .ch_en    (ch_en)
   );

   ext_irq_detect #(
      .NUM_CH (NUM_CH)
   ) det_i (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (sync_s),
      .ch_en (ch_en),
      .mode  (mode_q),
      .pol   (pol_q),
      .prev  (sync_p),
      .trig  (trig)
   );

   ext_irq_regs #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .trig      (trig),
      .mode_q    (mode_q),
      .pol_q     (pol_q),
      .flag_q    (flag_q),
      .clr_vec   (clr_vec)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_req
      if (n == SHARED_CH) begin : g_shared
         assign irq_req[n] = flag_q[n] | gpio_irq;
      end else begin : g_plain
         assign irq_req[n] = flag_q[n];
      end
   end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned SHARED_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] trig,
   input logic [NUM_CH-1:0] clr_vec,
   input logic [NUM_CH-1:0] flag_q,
   input logic [NUM_CH-1:0] mode_q,
   input logic [NUM_CH-1:0] sync_s,
   input logic [NUM_CH-1:0] sync_p,
   input logic              gpio_irq,
   input logic [NUM_CH-1:0] irq_req
);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig != '0) |=> ((~flag_q & $past(trig)) == '0));

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~clr_vec) != '0) |=> ((~flag_q & $past(flag_q & ~clr_vec)) == '0));

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & clr_vec & ~trig) != '0) |=> ((flag_q & $past(flag_q & clr_vec & ~trig)) == '0));

   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~ch_en & ~flag_q) != '0) |=> ((flag_q & $past(~ch_en & ~flag_q)) == '0));

   // R4
   edge_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q & ~(sync_s ^ sync_p) & trig) == '0));

   // R10
   shared_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gpio_irq |-> irq_req[SHARED_CH]);

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
   .NUM_CH    (NUM_CH),
   .SHARED_CH (SHARED_CH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ch_en    (ch_en),
   .trig     (trig),
   .clr_vec  (clr_vec),
   .flag_q   (flag_q),
   .mode_q   (mode_q),
   .sync_s   (sync_s),
   .sync_p   (sync_p),
   .gpio_irq (gpio_irq),
   .irq_req  (irq_req)
);

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ext_pin = 4'hF;
   logic        gpio_irq = 1'b0;
   logic [7:0]  pin_func = 8'h00;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_req;

   int checks = 0;
   int fails  = 0;

   // bench model state, built from the requirements
   logic [3:0] m_d1 = 4'h0, m_s = 4'h0, m_p = 4'h0;
   logic [3:0] m_flag = 4'h0, m_mode = 4'h0, m_pol = 4'h0;

   always #5 clk = ~clk;

   ext_irq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_pin   (ext_pin),
      .gpio_irq  (gpio_irq),
      .pin_func  (pin_func),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_req   (irq_req)
   );

   function automatic logic [3:0] en_of(input logic [7:0] f);
      logic [3:0] e;
      for (int n = 0; n < 4; n++) e[n] = (f[2*n +: 2] == 2'b01);
      return e;
   endfunction

   function automatic logic [3:0] trig_of(input logic [3:0] en, input logic [3:0] md,
                                          input logic [3:0] pl, input logic [3:0] s,
                                          input logic [3:0] p);
      logic [3:0] lvl;
      lvl = ~(s ^ pl);
      return en & ((md & lvl & (s ^ p)) | (~md & lvl));
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input logic [3:0] pins, input logic gp, input logic [7:0] func,
                       input logic wr, input logic [3:0] addr, input logic [31:0] data);
      logic [3:0] t, clr;
      ext_pin = pins; gpio_irq = gp; pin_func = func;
      bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = data;
      @(posedge clk);
      t   = trig_of(en_of(func), m_mode, m_pol, m_s, m_p);
      clr = (wr && addr[3:2] == 2'd0) ? data[3:0] : 4'h0;
      m_flag = t | (m_flag & ~clr);
      if (wr && addr[3:2] == 2'd1) m_mode = data[3:0];
      if (wr && addr[3:2] == 2'd2) m_pol  = data[3:0];
      m_p = m_s; m_s = m_d1; m_d1 = pins;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      // R5 R10: request lines follow the flags, line 3 also follows gpio_irq
      chk(irq_req == (m_flag | {gp, 3'b000}), "R5/R10 model", {28'h0, irq_req},
          {28'h0, m_flag | {gp, 3'b000}});
   endtask

   task automatic idle(input logic [3:0] pins, input int n);
      for (int i = 0; i < n; i++) step(pins, gpio_irq, pin_func, 1'b0, 4'h0, 32'h0);
   endtask

   task automatic rd(input logic [3:0] addr, input logic [31:0] exp, input string req);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
      #1;
      chk(bus_rdata == exp, req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(irq_req == 4'h0, "R1 irq", {28'h0, irq_req}, 32'h0);
      rd(4'h0, 32'h0, "R1 flag");
      rd(4'h4, 32'h0, "R1 mode");
      rd(4'h8, 32'h0, "R1 pol");

      // R2 register map, upper bits read zero
      idle(4'hF, 4);
      step(4'hF, 1'b0, 8'h00, 1'b1, 4'h4, 32'hFFFF_FFF5);
      rd(4'h4, 32'h5, "R2 mode readback");
      rd(4'hC, 32'h0, "R2 unmapped");
      step(4'hF, 1'b0, 8'h00, 1'b1, 4'h8, 32'hABCD_0002);
      rd(4'h8, 32'h2, "R2 pol readback");
      step(4'hF, 1'b0, 8'h00, 1'b1, 4'h4, 32'h2);  // ch1 edge, rest level

      // enable ch0, ch1, ch3; ch2 gets function 2'b10
      pin_func = 8'b01_10_01_01;
      idle(4'hF, 3);
      // R4 steady levels trigger nothing
      chk(irq_req == 4'h0, "R4 steady", {28'h0, irq_req}, 32'h0);

      // R3 level low on ch0: third edge
      idle(4'hE, 2);
      chk(irq_req[0] == 1'b0, "R3 latency early", {31'h0, irq_req[0]}, 32'h0);
      idle(4'hE, 1);
      chk(irq_req[0] == 1'b1, "R3 level low", {31'h0, irq_req[0]}, 32'h1);
      // R7 clear while pin still active
      step(4'hE, 1'b0, pin_func, 1'b1, 4'h0, 32'h1);
      chk(irq_req[0] == 1'b1, "R7 reassert", {31'h0, irq_req[0]}, 32'h1);
      idle(4'hF, 3);
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'h1);
      chk(irq_req[0] == 1'b0, "R6 clear", {31'h0, irq_req[0]}, 32'h0);

      // R4 ch1 rising edge only
      idle(4'hD, 4);
      chk(irq_req[1] == 1'b0, "R4 falling ignored", {31'h0, irq_req[1]}, 32'h0);
      idle(4'hF, 3);
      chk(irq_req[1] == 1'b1, "R4 rising", {31'h0, irq_req[1]}, 32'h1);
      // R6 zero writes and other bits leave it set
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'h0);
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'h1);
      chk(irq_req[1] == 1'b1, "R6 no effect", {31'h0, irq_req[1]}, 32'h1);
      rd(4'h0, 32'h2, "R5 flag readback");

      // R8 clear lands with a new rising edge
      idle(4'hD, 3);
      step(4'hF, 1'b0, pin_func, 1'b0, 4'h0, 32'h0);
      step(4'hF, 1'b0, pin_func, 1'b0, 4'h0, 32'h0);
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'h2);
      chk(irq_req[1] == 1'b1, "R8 set wins", {31'h0, irq_req[1]}, 32'h1);
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'h2);
      chk(irq_req[1] == 1'b0, "R4 no retrigger", {31'h0, irq_req[1]}, 32'h0);

      // R9 ch2 disabled, then enabled with pin already active
      idle(4'hB, 4);
      chk(irq_req[2] == 1'b0, "R9 disabled", {31'h0, irq_req[2]}, 32'h0);
      rd(4'h0, 32'h0, "R9 flag readback");
      step(4'hB, 1'b0, 8'b01_01_01_01, 1'b0, 4'h0, 32'h0);
      chk(irq_req[2] == 1'b1, "R9 enable", {31'h0, irq_req[2]}, 32'h1);
      idle(4'hF, 3);
      step(4'hF, 1'b0, pin_func, 1'b1, 4'h0, 32'hF);

      // R10 shared GPIO input
      step(4'hF, 1'b1, pin_func, 1'b0, 4'h0, 32'h0);
      chk(irq_req[3] == 1'b1, "R10 gpio", {31'h0, irq_req[3]}, 32'h1);
      rd(4'h0, 32'h0, "R10 flag untouched");
      step(4'hF, 1'b0, pin_func, 1'b0, 4'h0, 32'h0);
      chk(irq_req[3] == 1'b0, "R10 gpio low", {31'h0, irq_req[3]}, 32'h0);

      // random phase against the bench model (R3 R4 R6 R7 R8 R9)
      for (int blk = 0; blk < 10; blk++) begin
         logic [7:0] f;
         for (int n = 0; n < 4; n++)
            f[2*n +: 2] = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
         step(ext_pin, 1'b0, f, 1'b1, 4'h4, $urandom);
         step(ext_pin, 1'b0, f, 1'b1, 4'h8, $urandom);
         for (int i = 0; i < 60; i++) begin
            logic [3:0] pins;
            logic       w;
            pins = ext_pin;
            if ($urandom % 3 == 0) pins = pins ^ 4'(1 << ($urandom % 4));
            w = ($urandom % 5 == 0);
            step(pins, ($urandom % 8 == 0), f, w, 4'h0, $urandom);
         end
         rd(4'h0, {28'h0, m_flag}, "R5 random readback");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule